// File: doc/BRIEF.md
# Trap Entry and Privilege Delegation Unit

This unit carries out trap entry for a hart with three privilege levels: user, supervisor and machine. A trap is requested by a one-cycle pulse. With it come a 6-bit trap code, a flag that marks the trap as an interrupt or an exception, the privilege the hart is running at, the live image of the status register, the address of the trapping instruction and a trap value. The unit chooses the level that will handle the trap. It starts from machine and consults two pairs of delegation masks, one mask per trap kind for each of the two lower levels. It then writes that level's cause, return-address and trap-value registers, stacks the level's interrupt enable, and records the new privilege. It also produces the handler address from that level's vector-base input. Any vector base with mode 1 gives interrupts a per-code vectored entry.

The trap's register updates all commit on the clock edge that samples the request. On the next cycle a one-cycle redirect strobe presents the handler address to the fetch logic. While reset is held, the unit returns to machine privilege, clears the status image and every cause register, and drives the redirect strobe with a fixed reset address.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `priv_q` becomes 3 (machine), `status_q` becomes all zero (including the machine interrupt enable and the modify-privilege bit), every cause register becomes 0, `redirect_valid` is 1 and `redirect_pc` equals `RESET_VEC`; the first edge after release without a request drops `redirect_valid`.
- R2: Privilege encoding is user = 0, supervisor = 1, machine = 3. The target level is machine unless a delegation rule moves it; a trap taken at machine privilege always targets machine, whatever the masks hold.
- R3: When the running privilege is not machine and bit [code] of the supervisor-delegation mask for the trap's kind is set, the target is supervisor. Interrupts use `dlg_irq_s` only, and exceptions use `dlg_exc_s` only.
- R4: After that rule, when the running privilege is user and bit [code] of `dlg_irq_u` (interrupts) or `dlg_exc_u` (exceptions) is set, the target is user, even if the supervisor mask bit is clear. At supervisor privilege the user masks have no effect.
- R5: Status bit positions: 0 uie, 1 sie, 2 mie, 3 upie, 4 spie, 5 mpie, 6 spp, 8:7 mpp, 9 mprv. Entry to machine writes mpp with the running privilege, mpie with the old mie, and clears mie.
- R6: Entry to supervisor writes spp with bit 0 of the running privilege, spie with the old sie, and clears sie.
- R7: Entry to user writes upie with the old uie and clears uie. For every target, all status bits that the entry does not name keep their incoming values.
- R8: The cause written holds the trap code in its low bits and has bit XLEN-1 set exactly when the trap is an interrupt.
- R9: Only the target level's cause, return-address and trap-value registers change on a trap. The return address takes `trap_pc` and the trap value takes `trap_val`.
- R10: The handler address is the target's vector base with bits 1:0 cleared; for an interrupt whose vector-base bits 1:0 equal 1, 4 × code is added.
- R11: Exceptions always use the plain base, and vector-base modes 2 and 3 behave like mode 0.
- R12: State updates on the edge where `trap_req` is high; `redirect_valid` is high for exactly the following cycle. Without a request, no register changes and `redirect_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Trap code |
| cur_priv | input | 2 | Privilege the hart runs at |
| cur_status | input | 10 | Live status image |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_val | input | XLEN | Trap value |
| dlg_irq_s | input | 2**CODE_W | Interrupt delegation to supervisor |
| dlg_exc_s | input | 2**CODE_W | Exception delegation to supervisor |
| dlg_irq_u | input | 2**CODE_W | Interrupt delegation to user |
| dlg_exc_u | input | 2**CODE_W | Exception delegation to user |
| hvec_m | input | XLEN | Machine vector base and mode |
| hvec_s | input | XLEN | Supervisor vector base and mode |
| hvec_u | input | XLEN | User vector base and mode |
| priv_q | output | 2 | Privilege after the last trap |
| status_q | output | 10 | Status image after the last trap |
| cause_m | output | XLEN | Machine cause |
| cause_s | output | XLEN | Supervisor cause |
| cause_u | output | XLEN | User cause |
| epc_m | output | XLEN | Machine return address |
| epc_s | output | XLEN | Supervisor return address |
| epc_u | output | XLEN | User return address |
| tval_m | output | XLEN | Machine trap value |
| tval_s | output | XLEN | Supervisor trap value |
| tval_u | output | XLEN | User trap value |
| redirect_valid | output | 1 | Handler redirect strobe |
| redirect_pc | output | XLEN | Handler or reset address |

## Verification
The assertions assume that `cur_priv` never carries the reserved value 2. The privilege-ordering check holds only under that assumption. They also assume that reset is held for at least two edges, so the stability check never compares against a register value from before reset. The stimulus uses only the codes 0, 1 and 3 for the running privilege and holds reset for five cycles each time. It drives every request for a single cycle with idle gaps between requests, and keeps `RESET_VEC` word aligned.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CODE_W_DEF = 6;
    localparam int NLEVELS    = 3;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    // bit 0 is uie, bit 9 is mprv
    typedef struct packed {
        logic       mprv;
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       upie;
        logic       mie;
        logic       sie;
        logic       uie;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    // register bank index: user 0, supervisor 1, machine 2
    function automatic logic [1:0] bank_of(priv_e p);
        case (p)
            PRIV_U:  return 2'd0;
            PRIV_S:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
    import trap_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    localparam int DW    = 1 << CODE_W
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        cur,
    input  logic [DW-1:0]     irq_to_s,
    input  logic [DW-1:0]     exc_to_s,
    input  logic [DW-1:0]     irq_to_u,
    input  logic [DW-1:0]     exc_to_u,
    output priv_e             target
);
    logic to_s_bit;
    logic to_u_bit;

    always_comb begin
        to_s_bit = is_irq ? irq_to_s[code] : exc_to_s[code];
        to_u_bit = is_irq ? irq_to_u[code] : exc_to_u[code];
        target   = PRIV_M;
        if (cur != PRIV_M && to_s_bit) begin
            target = PRIV_S;
        end
        // user rule is applied last and wins over the supervisor rule
        if (cur == PRIV_U && to_u_bit) begin
            target = PRIV_U;
        end
    end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
    import trap_pkg::*;
(
    input  status_t    cur_st,
    input  logic [1:0] cur,
    input  priv_e      target,
    output status_t    nxt_st
);
    always_comb begin
        nxt_st = cur_st;
        case (target)
            PRIV_M: begin
                nxt_st.mpp  = cur;
                nxt_st.mpie = cur_st.mie;
                nxt_st.mie  = 1'b0;
            end
            PRIV_S: begin
                nxt_st.spp  = cur[0];
                nxt_st.spie = cur_st.sie;
                nxt_st.sie  = 1'b0;
            end
            default: begin
                nxt_st.upie = cur_st.uie;
                nxt_st.uie  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
    parameter int XLEN   = 64,
    parameter int CODE_W = 6
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   hvec,
    output logic [XLEN-1:0]   handler_pc
);
    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {hvec[XLEN-1:2], 2'b00};
        offset = XLEN'(code) << 2;
        if (is_irq && hvec[1:0] == MODE_VECTORED) begin
            handler_pc = base + offset;
        end else begin
            handler_pc = base;
        end
    end
endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] cause_d,
    input  logic [XLEN-1:0] epc_d,
    input  logic [XLEN-1:0] tval_d,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] tval_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
            tval_q  <= '0;
        end else if (we) begin
            cause_q <= cause_d;
            epc_q   <= epc_d;
            tval_q  <= tval_d;
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CODE_W    = CODE_W_DEF,
    parameter logic [XLEN-1:0] RESET_VEC = 'h1000,
    localparam int             DW        = 1 << CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trap_req,
    input  logic                trap_is_irq,
    input  logic [CODE_W-1:0]   trap_code,
    input  logic [1:0]          cur_priv,
    input  logic [STATUS_W-1:0] cur_status,
    input  logic [XLEN-1:0]     trap_pc,
    input  logic [XLEN-1:0]     trap_val,
    input  logic [DW-1:0]       dlg_irq_s,
    input  logic [DW-1:0]       dlg_exc_s,
    input  logic [DW-1:0]       dlg_irq_u,
    input  logic [DW-1:0]       dlg_exc_u,
    input  logic [XLEN-1:0]     hvec_m,
    input  logic [XLEN-1:0]     hvec_s,
    input  logic [XLEN-1:0]     hvec_u,
    output logic [1:0]          priv_q,
    output logic [STATUS_W-1:0] status_q,
    output logic [XLEN-1:0]     cause_m,
    output logic [XLEN-1:0]     cause_s,
    output logic [XLEN-1:0]     cause_u,
    output logic [XLEN-1:0]     epc_m,
    output logic [XLEN-1:0]     epc_s,
    output logic [XLEN-1:0]     epc_u,
    output logic [XLEN-1:0]     tval_m,
    output logic [XLEN-1:0]     tval_s,
    output logic [XLEN-1:0]     tval_u,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc
);
    priv_e           target;
    logic [1:0]      tgt_bank;
    status_t         st_in;
    status_t         st_next;
    status_t         st_r;
    priv_e           priv_r;
    logic [XLEN-1:0] cause_val;
    logic [XLEN-1:0] hvec_sel;
    logic [XLEN-1:0] handler_pc;
    logic            rdr_v_r;
    logic [XLEN-1:0] rdr_pc_r;

    logic [XLEN-1:0] cause_a [NLEVELS];
    logic [XLEN-1:0] epc_a   [NLEVELS];
    logic [XLEN-1:0] tval_a  [NLEVELS];

    assign st_in = status_t'(cur_status);

    trap_target_sel #(.CODE_W(CODE_W)) u_sel (
        .is_irq   (trap_is_irq),
        .code     (trap_code),
        .cur      (cur_priv),
        .irq_to_s (dlg_irq_s),
        .exc_to_s (dlg_exc_s),
        .irq_to_u (dlg_irq_u),
        .exc_to_u (dlg_exc_u),
        .target   (target)
    );

    trap_status_stack u_stack (
        .cur_st (st_in),
        .cur    (cur_priv),
        .target (target),
        .nxt_st (st_next)
    );

    always_comb begin
        tgt_bank = bank_of(target);
        cause_val = XLEN'(trap_code);
        cause_val[XLEN-1] = trap_is_irq;
        case (target)
            PRIV_U:  hvec_sel = hvec_u;
            PRIV_S:  hvec_sel = hvec_s;
            default: hvec_sel = hvec_m;
        endcase
    end

    trap_vec_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
        .is_irq     (trap_is_irq),
        .code       (trap_code),
        .hvec       (hvec_sel),
        .handler_pc (handler_pc)
    );

    for (genvar g = 0; g < NLEVELS; g++) begin : g_bank
        trap_level_regs #(.XLEN(XLEN)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .we      (trap_req && tgt_bank == 2'(g)),
            .cause_d (cause_val),
            .epc_d   (trap_pc),
            .tval_d  (trap_val),
            .cause_q (cause_a[g]),
            .epc_q   (epc_a[g]),
            .tval_q  (tval_a[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_r   <= PRIV_M;
            st_r     <= '0;
            rdr_v_r  <= 1'b1;
            rdr_pc_r <= RESET_VEC;
        end else begin
            rdr_v_r <= trap_req;
            if (trap_req) begin
                priv_r   <= target;
                st_r     <= st_next;
                rdr_pc_r <= handler_pc;
            end
        end
    end

    assign priv_q         = priv_r;
    assign status_q       = st_r;
    assign redirect_valid = rdr_v_r;
    assign redirect_pc    = rdr_pc_r;
    assign cause_u        = cause_a[0];
    assign cause_s        = cause_a[1];
    assign cause_m        = cause_a[2];
    assign epc_u          = epc_a[0];
    assign epc_s          = epc_a[1];
    assign epc_m          = epc_a[2];
    assign tval_u         = tval_a[0];
    assign tval_s         = tval_a[1];
    assign tval_m         = tval_a[2];

    AST_MACHINE_KEEPS_MACHINE: assert property (@(posedge clk) disable iff (rst)
        trap_req && cur_priv == PRIV_M |=> priv_q == PRIV_M); // R2

    AST_TARGET_NOT_BELOW_SOURCE: assert property (@(posedge clk) disable iff (rst)
        trap_req && cur_priv != 2'd2 |=> priv_q >= $past(cur_priv)); // R3

    AST_MACHINE_ENTRY_MASKS: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_r != PRIV_M) || !st_r.mie); // R5

    AST_REDIRECT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> redirect_valid); // R12

    AST_NO_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> !redirect_valid); // R12

    AST_CAUSE_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> $stable(cause_m) && $stable(cause_s) && $stable(cause_u)); // R9

    AST_HANDLER_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> redirect_pc[1:0] == 2'b00); // R10

endmodule

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
    import trap_pkg::*;

    localparam int          XLEN = 64;
    localparam int          CW   = 6;
    localparam int          DW   = 1 << CW;
    localparam logic [63:0] RVEC = 64'h1000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            trap_req = 1'b0;
    logic            trap_is_irq = 1'b0;
    logic [CW-1:0]   trap_code = '0;
    logic [1:0]      cur_priv = 2'd3;
    logic [9:0]      cur_status = '0;
    logic [63:0]     trap_pc = '0;
    logic [63:0]     trap_val = '0;
    logic [DW-1:0]   dlg_irq_s, dlg_exc_s, dlg_irq_u, dlg_exc_u;
    logic [63:0]     hvec_m, hvec_s, hvec_u;
    logic [1:0]      priv_q;
    logic [9:0]      status_q;
    logic [63:0]     cause_m, cause_s, cause_u, epc_m, epc_s, epc_u, tval_m, tval_s, tval_u;
    logic            redirect_valid;
    logic [63:0]     redirect_pc;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] mc [3];
    logic [63:0] me [3];
    logic [63:0] mt [3];

    always #5 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CW), .RESET_VEC(RVEC)) u_dut (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .cur_priv(cur_priv), .cur_status(cur_status),
        .trap_pc(trap_pc), .trap_val(trap_val),
        .dlg_irq_s(dlg_irq_s), .dlg_exc_s(dlg_exc_s),
        .dlg_irq_u(dlg_irq_u), .dlg_exc_u(dlg_exc_u),
        .hvec_m(hvec_m), .hvec_s(hvec_s), .hvec_u(hvec_u),
        .priv_q(priv_q), .status_q(status_q),
        .cause_m(cause_m), .cause_s(cause_s), .cause_u(cause_u),
        .epc_m(epc_m), .epc_s(epc_s), .epc_u(epc_u),
        .tval_m(tval_m), .tval_s(tval_s), .tval_u(tval_u),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    typedef struct packed {
        logic          irq;
        logic [CW-1:0] code;
        logic [1:0]    cur;
        logic [1:0]    tgt;
    } vec_t;

    // masks: irq->S bits 1,5,9; exc->S bits 2,8; irq->U bits 0,1,4; exc->U bits 8,12
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd5,  2'd0, 2'd1},
        '{1'b1, 6'd5,  2'd3, 2'd3},
        '{1'b1, 6'd1,  2'd0, 2'd0},
        '{1'b1, 6'd1,  2'd1, 2'd1},
        '{1'b1, 6'd4,  2'd0, 2'd0},
        '{1'b1, 6'd4,  2'd1, 2'd3},
        '{1'b0, 6'd2,  2'd1, 2'd1},
        '{1'b0, 6'd5,  2'd0, 2'd3},
        '{1'b0, 6'd8,  2'd0, 2'd0},
        '{1'b0, 6'd12, 2'd0, 2'd0},
        '{1'b0, 6'd12, 2'd1, 2'd3},
        '{1'b1, 6'd9,  2'd1, 2'd1},
        '{1'b1, 6'd63, 2'd3, 2'd3},
        '{1'b0, 6'd9,  2'd1, 2'd3}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_status(logic [9:0] st, logic [1:0] cur, logic [1:0] tgt);
        logic [9:0] r = st;
        if (tgt == 2'd3) begin
            r[8:7] = cur; r[5] = st[2]; r[2] = 1'b0;
        end else if (tgt == 2'd1) begin
            r[6] = cur[0]; r[4] = st[1]; r[1] = 1'b0;
        end else begin
            r[3] = st[0]; r[0] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_pc(logic irq, logic [CW-1:0] code, logic [1:0] tgt);
        logic [63:0] tv = (tgt == 2'd3) ? hvec_m : (tgt == 2'd1) ? hvec_s : hvec_u;
        logic [63:0] b  = tv & ~64'h3;
        if (irq && tv[1:0] == 2'd1) b = b + 64'(code) * 64'd4;
        return b;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin
            mc[k] = '0; me[k] = '0; mt[k] = '0;
        end
    endtask

    task automatic check_banks(string req);
        check({req, " cause_u"}, cause_u, mc[0]);
        check({req, " cause_s"}, cause_s, mc[1]);
        check({req, " cause_m"}, cause_m, mc[2]);
        check({req, " epc_u"},   epc_u,   me[0]);
        check({req, " epc_s"},   epc_s,   me[1]);
        check({req, " epc_m"},   epc_m,   me[2]);
        check({req, " tval_u"},  tval_u,  mt[0]);
        check({req, " tval_s"},  tval_s,  mt[1]);
        check({req, " tval_m"},  tval_m,  mt[2]);
    endtask

    // called at a negedge; returns at the negedge after the request edge
    task automatic fire(logic irq, logic [CW-1:0] code, logic [1:0] cur, logic [1:0] tgt,
                        logic [9:0] st, logic [63:0] pc, logic [63:0] val, string tag);
        logic [63:0] cz;
        int          bank;
        trap_is_irq = irq; trap_code = code; cur_priv = cur;
        cur_status = st; trap_pc = pc; trap_val = val; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        bank = (tgt == 2'd3) ? 2 : int'(tgt);
        cz = 64'(code);
        cz[63] = irq;
        mc[bank] = cz; me[bank] = pc; mt[bank] = val;
        check({tag, " R2 R3 R4 target priv"}, 64'(priv_q), 64'(tgt));
        check({tag, " R5 R6 R7 status"}, 64'(status_q), 64'(exp_status(st, cur, tgt)));
        check({tag, " R12 redirect strobe"}, 64'(redirect_valid), 64'd1);
        check({tag, " R10 R11 handler pc"}, redirect_pc, exp_pc(irq, code, tgt));
        check_banks({tag, " R8 R9"});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        model_reset();
        check("R1 reset priv", 64'(priv_q), 64'd3);
        check("R1 reset status", 64'(status_q), 64'd0);
        check("R1 reset mcause", cause_m, 64'd0);
        check("R1 reset redirect valid", 64'(redirect_valid), 64'd1);
        check("R1 reset redirect pc", redirect_pc, RVEC);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobe drops after release", 64'(redirect_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        dlg_irq_s = 64'h222;
        dlg_exc_s = 64'h104;
        dlg_irq_u = 64'h13;
        dlg_exc_u = 64'h1100;
        hvec_m    = 64'h8000_0001;
        hvec_s    = 64'h4000_0003;
        hvec_u    = 64'h2000_0101;
        model_reset();
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            logic [9:0] st = 10'((i * 93 + 341) % 1024);
            fire(VECS[i].irq, VECS[i].code, VECS[i].cur, VECS[i].tgt, st,
                 64'h1_0000 + 64'(i) * 64'd4, 64'hBEEF_0000 + 64'(i), $sformatf("vec%0d", i));
            // idle cycle: no change, no strobe (R12)
            @(negedge clk);
            check("R12 idle strobe low", 64'(redirect_valid), 64'd0);
            check_banks("R12 idle banks held");
        end

        // R2: machine source with every delegation bit set
        dlg_irq_s = '1; dlg_exc_s = '1; dlg_irq_u = '1; dlg_exc_u = '1;
        fire(1'b1, 6'd7, 2'd3, 2'd3, 10'h3FF, 64'h2000, 64'h11, "R2 all masks set");
        @(negedge clk);
        // R4: supervisor source ignores user masks
        fire(1'b0, 6'd3, 2'd1, 2'd1, 10'h2A5, 64'h2004, 64'h12, "R4 s ignores u mask");
        @(negedge clk);
        fire(1'b0, 6'd3, 2'd0, 2'd0, 10'h15B, 64'h2008, 64'h13, "R4 user both masks");
        @(negedge clk);

        // R11: mode 2 on machine base, interrupt still direct; R8 code 0 interrupt
        dlg_irq_s = '0; dlg_exc_s = '0; dlg_irq_u = '0; dlg_exc_u = '0;
        hvec_m = 64'h9000_0002;
        fire(1'b1, 6'd0, 2'd0, 2'd3, 10'h001, 64'h3000, 64'h14, "R11 R8 mode2 code0");
        check("R8 interrupt code0 cause", cause_m, 64'h8000_0000_0000_0000);
        @(negedge clk);
        // R10: vectored interrupt, top code
        hvec_m = 64'h9000_0001;
        fire(1'b1, 6'd63, 2'd1, 2'd3, 10'h004, 64'h3004, 64'h15, "R10 vectored code63");
        check("R10 vectored pc", redirect_pc, 64'h9000_0000 + 64'd252);
        @(negedge clk);
        // R11: exception at vectored base takes plain base
        fire(1'b0, 6'd63, 2'd1, 2'd3, 10'h004, 64'h3008, 64'h16, "R11 exception base");
        check("R11 exception pc", redirect_pc, 64'h9000_0000);
        @(negedge clk);

        // R1: reset after traps
        do_reset();
        check_banks("R1 banks cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule